// File: doc/BRIEF.md
# Event Counter with Shared Divider

This block is an 8-bit event counter whose input passes through a power-of-two divider. The divider can be switched away from the counter to serve a separate watchdog. A 6-bit mode word selects four things: the divide ratio, which side owns the divider, the edge polarity on the external pin, and whether the counter counts instruction cycles or pin edges.

When the watchdog owns the divider, the counter advances once per selected event. The watchdog then receives a divided tick derived from the instruction-cycle enable. When the counter owns the divider, the watchdog receives an undivided tick on every instruction cycle.

Software can load the counter value directly and can rewrite the mode word. The counter rolls over from all ones to zero and flags each rollover with a single-cycle pulse. The watchdog counter itself lies outside this block; it consumes the tick output.

Top module: `evt_timer`

## Requirements
- R1: A synchronous active-high reset clears the counter, the rollover pulse and the watchdog tick. It also sets the mode word to 6'h3F: external pin source, falling edge, divider owned by the watchdog, rate code 7.
- R2: The mode word is laid out as follows. Bits [2:0] hold the rate code. Bit 3 selects the divider owner (0 = counter, 1 = watchdog). Bit 4 selects the pin edge (0 = rising, 1 = falling). Bit 5 selects the source (0 = instruction-cycle enable, 1 = pin edges). The outputs follow the reference model for any sequence of mode words.
- R3: When the counter owns the divider, it advances once every 2^(code+1) source events, so code 0 divides by 2 and code 7 divides by 256.
- R4: When the watchdog owns the divider, the counter advances on every source event. The watchdog tick then pulses once every 2^code instruction-cycle enables, so code 0 divides by 1 and code 7 divides by 128.
- R5: When the counter owns the divider, the watchdog tick equals the instruction-cycle enable of the previous clock.
- R6: The pin is sampled on every clock. A transition of the selected polarity gives exactly one event, a steady level gives none, and a transition of the other polarity gives none.
- R7: With the instruction-cycle source selected, pin activity does not change the counter.
- R8: A counter write loads the value at the next clock and overrides a same-cycle increment. If the counter owns the divider, the write also clears the divider, so a full ratio of events is needed before the next increment.
- R9: The counter wraps from 8'hFF to 8'h00. The rollover output is high for exactly the one cycle in which the counter reads 8'h00 after the wrap.
- R10: Any mode write clears the divider, even when the new mode word equals the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_en | input | 1 | Instruction-cycle enable, one clock per cycle |
| ext_pin | input | 1 | External count pin, already synchronized |
| mode_we | input | 1 | Mode word write strobe |
| mode_wdata | input | 6 | Mode word write data |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | CNT_W | Counter write data |
| cnt_value | output | CNT_W | Current counter value |
| cnt_ovf | output | 1 | Single-cycle rollover pulse |
| wdog_tick | output | 1 | Tick towards the watchdog counter |

## Verification
The bench goes after the two meanings of the rate code. A design that used the same shift for both owners would advance the counter, or tick the watchdog, at twice or half the expected rate.

It also targets the following cases:
- A counter write that lands in the cycle where the divider would fire. A wrong design would store the written value plus one.
- A write that fails to clear the divider. This shows up as an early increment after the load.
- A mode rewrite with an unchanged value. This exposes a divider that is only cleared when the owner changes.
- A pin held high for several cycles, and edges of the wrong polarity. Both expose level counting or a swapped polarity.
- A wrap from 8'hFF. This exposes a rollover pulse that lasts longer than one cycle or fires on a load.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  localparam int RATE_W = 3;
  localparam int MODE_W = RATE_W + 3;

  typedef struct packed {
    logic              src_pin;
    logic              fall_edge;
    logic              psc_to_wdt;
    logic [RATE_W-1:0] rate;
  } mode_t;

  localparam mode_t MODE_RST = '{src_pin: 1'b1, fall_edge: 1'b1, psc_to_wdt: 1'b1, rate: '1};

endpackage

// File: rtl/evt_edge_sense.sv
module evt_edge_sense (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic fall_sel,
  output logic evt
);
  logic pin_q;

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else     pin_q <= pin;
  end

  always_comb begin
    if (fall_sel) evt = pin_q & ~pin;
    else          evt = pin & ~pin_q;
  end
endmodule

// File: rtl/evt_prescaler.sv
module evt_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         evt_in,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] count_q;

  assign tick = evt_in && (count_q == limit);

  always_ff @(posedge clk) begin
    if (rst || clr)  count_q <= '0;
    else if (evt_in) count_q <= tick ? '0 : count_q + 1'b1;
  end
endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         inc,
  output logic [W-1:0] value,
  output logic         ovf
);
  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
      ovf   <= 1'b0;
    end else begin
      ovf <= 1'b0;
      if (we) begin
        value <= wdata;
      end else if (inc) begin
        value <= value + 1'b1;
        ovf   <= &value;
      end
    end
  end
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_en,
  input  logic             ext_pin,
  input  logic             mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt_value,
  output logic             cnt_ovf,
  output logic             wdog_tick
);
  localparam int PSC_W = 1 << RATE_W;
  localparam logic [PSC_W:0] SPAN_ONE = 1;
  localparam logic [PSC_W:0] SPAN_TWO = 2;

  mode_t            mode_q;
  logic             pin_evt;
  logic             src_evt;
  logic             psc_in;
  logic             psc_clr;
  logic             psc_tick;
  logic             cnt_inc;
  logic [PSC_W:0]   span;
  logic [PSC_W:0]   span_m1;
  logic [PSC_W-1:0] psc_limit;

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= MODE_RST;
    else if (mode_we) mode_q <= mode_t'(mode_wdata);
  end

  evt_edge_sense u_edge (
    .clk      (clk),
    .rst      (rst),
    .pin      (ext_pin),
    .fall_sel (mode_q.fall_edge),
    .evt      (pin_evt)
  );

  assign src_evt = mode_q.src_pin ? pin_evt : cyc_en;
  assign psc_in  = mode_q.psc_to_wdt ? cyc_en : src_evt;
  assign psc_clr = mode_we | (cnt_we & ~mode_q.psc_to_wdt);

  // Same code field: watchdog side divides by 2^code, counter side by 2^(code+1).
  always_comb begin
    if (mode_q.psc_to_wdt) span = SPAN_ONE << mode_q.rate;
    else                   span = SPAN_TWO << mode_q.rate;
    span_m1   = span - SPAN_ONE;
    psc_limit = span_m1[PSC_W-1:0];
  end

  evt_prescaler #(.W(PSC_W)) u_psc (
    .clk    (clk),
    .rst    (rst),
    .clr    (psc_clr),
    .evt_in (psc_in),
    .limit  (psc_limit),
    .tick   (psc_tick)
  );

  assign cnt_inc = mode_q.psc_to_wdt ? src_evt : psc_tick;

  evt_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .we    (cnt_we),
    .wdata (cnt_wdata),
    .inc   (cnt_inc),
    .value (cnt_value),
    .ovf   (cnt_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) wdog_tick <= 1'b0;
    else     wdog_tick <= mode_q.psc_to_wdt ? psc_tick : cyc_en;
  end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cyc_en,
  input logic             cnt_we,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic [CNT_W-1:0] cnt_value,
  input logic             cnt_ovf,
  input logic             wdog_tick,
  input logic [5:0]       mode_q
);
  p_wrap_zero_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_ovf |-> (cnt_value == '0));

  p_ovf_single_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_ovf |=> !cnt_ovf);

  p_load_r8: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> (cnt_value == $past(cnt_wdata)));

  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    !cnt_we |=> ((cnt_value == $past(cnt_value)) ||
                 (cnt_value == CNT_W'($past(cnt_value) + 1'b1))));

  p_wdt_follow_r5: assert property (@(posedge clk) disable iff (rst)
    !mode_q[3] |=> (wdog_tick == $past(cyc_en)));
endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cyc_en    (cyc_en),
  .cnt_we    (cnt_we),
  .cnt_wdata (cnt_wdata),
  .cnt_value (cnt_value),
  .cnt_ovf   (cnt_ovf),
  .wdog_tick (wdog_tick),
  .mode_q    (mode_q)
);

// File: tb/evt_timer_tb.sv
module evt_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_en = 1'b0;
  logic       ext_pin = 1'b0;
  logic       mode_we = 1'b0;
  logic [5:0] mode_wdata = '0;
  logic       cnt_we = 1'b0;
  logic [7:0] cnt_wdata = '0;
  logic [7:0] cnt_value;
  logic       cnt_ovf;
  logic       wdog_tick;

  int    n_checks = 0;
  int    n_errs = 0;
  int    n_cyc = 0;
  bit    chk_on = 1'b0;
  string cur_req = "R1";

  int m_cnt, m_psc, m_mode, m_pin, m_ovf, m_wdt;

  always #10 clk = ~clk;

  evt_timer u_dut (
    .clk(clk), .rst(rst), .cyc_en(cyc_en), .ext_pin(ext_pin),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .cnt_value(cnt_value), .cnt_ovf(cnt_ovf), .wdog_tick(wdog_tick)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  always @(posedge clk) begin
    int rise, fall, edge_ev, src, asg, ratio, p_ev, tick, inc;
    if (rst) begin
      m_cnt = 0; m_psc = 0; m_mode = 63; m_pin = 0; m_ovf = 0; m_wdt = 0;
    end else begin
      rise    = (ext_pin && !m_pin) ? 1 : 0;
      fall    = (!ext_pin && m_pin) ? 1 : 0;
      edge_ev = ((m_mode >> 4) & 1) ? fall : rise;
      src     = ((m_mode >> 5) & 1) ? edge_ev : int'(cyc_en);
      asg     = (m_mode >> 3) & 1;
      ratio   = asg ? (1 << (m_mode & 7)) : (2 << (m_mode & 7));
      p_ev    = asg ? int'(cyc_en) : src;
      tick    = (p_ev && (m_psc == ratio - 1)) ? 1 : 0;
      inc     = asg ? src : tick;
      m_wdt   = asg ? tick : int'(cyc_en);
      m_ovf   = 0;
      if (cnt_we) m_cnt = cnt_wdata;
      else if (inc) begin
        if (m_cnt == 255) begin m_cnt = 0; m_ovf = 1; end
        else m_cnt = m_cnt + 1;
      end
      if (mode_we || (cnt_we && !asg)) m_psc = 0;
      else if (p_ev) m_psc = tick ? 0 : m_psc + 1;
      if (mode_we) m_mode = mode_wdata;
      m_pin = ext_pin;
    end
  end

  always @(negedge clk) begin
    if (chk_on && !rst) begin
      chk(cur_req, "model cnt_value", cnt_value, m_cnt);
      chk(cur_req, "model cnt_ovf", cnt_ovf, m_ovf);
      chk(cur_req, "model wdog_tick", wdog_tick, m_wdt);
    end
  end

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 100000) begin
      n_errs++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", n_cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
      $finish;
    end
  end

  task automatic cyc(input logic ce);
    cyc_en = ce; mode_we = 1'b0; cnt_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic setpin(input logic p);
    ext_pin = p; cyc_en = 1'b0; mode_we = 1'b0; cnt_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_mode(input logic [5:0] m);
    cyc_en = 1'b0; mode_we = 1'b1; mode_wdata = m; cnt_we = 1'b0;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  task automatic wr_cnt(input logic [7:0] v, input logic ce);
    cyc_en = ce; cnt_we = 1'b1; cnt_wdata = v; mode_we = 1'b0;
    @(negedge clk);
    cnt_we = 1'b0; cyc_en = 1'b0;
  endtask

  initial begin
    int ticks;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_on = 1'b1;

    // R1 reset values
    cur_req = "R1";
    chk("R1", "cnt after reset", cnt_value, 0);
    chk("R1", "ovf after reset", cnt_ovf, 0);
    chk("R1", "wdog after reset", wdog_tick, 0);
    // reset mode: falling pin edges count directly
    setpin(1'b1);
    setpin(1'b0);
    chk("R1", "falling edge count in reset mode", cnt_value, 1);

    // R4 watchdog divide by 128 under reset mode
    cur_req = "R4";
    ticks = 0;
    for (int i = 0; i < 256; i++) begin cyc(1'b1); ticks += int'(wdog_tick); end
    cyc(1'b0); ticks += int'(wdog_tick);
    chk("R4", "wdog ticks over 256 cycles at code 7", ticks, 2);
    chk("R4", "cnt unaffected by cycles with pin source", cnt_value, 1);

    // R3 counter-side division
    cur_req = "R3";
    wr_mode(6'b000000);
    wr_cnt(8'h00, 1'b0);
    repeat (10) cyc(1'b1);
    chk("R3", "code 0 divides by 2", cnt_value, 5);
    wr_mode(6'b000011);
    cur_req = "R5";
    ticks = 0;
    for (int i = 0; i < 32; i++) begin cyc(1'b1); ticks += int'(wdog_tick); end
    chk("R3", "code 3 divides by 16", cnt_value, 7);
    chk("R5", "wdog ticks follow each cycle", ticks, 32);

    // R7 pin ignored with internal source
    cur_req = "R7";
    for (int i = 0; i < 8; i++) setpin(~ext_pin);
    chk("R7", "pin toggles ignored", cnt_value, 7);

    // R6 edge detection
    cur_req = "R6";
    wr_mode(6'b101000);
    wr_cnt(8'h00, 1'b0);
    setpin(1'b1); repeat (3) cyc(1'b0);
    chk("R6", "held high counts once", cnt_value, 1);
    setpin(1'b0); repeat (2) cyc(1'b0);
    chk("R6", "falling ignored when rising selected", cnt_value, 1);
    setpin(1'b1);
    chk("R6", "second rising edge", cnt_value, 2);
    wr_mode(6'b111000);
    setpin(1'b0);
    chk("R6", "falling counted when selected", cnt_value, 3);
    setpin(1'b1);
    chk("R6", "rising ignored when falling selected", cnt_value, 3);

    // R8 writes
    cur_req = "R8";
    wr_mode(6'b000010);
    wr_cnt(8'h10, 1'b0);
    repeat (5) cyc(1'b1);
    wr_cnt(8'h20, 1'b0);
    chk("R8", "load value", cnt_value, 32);
    repeat (7) cyc(1'b1);
    chk("R8", "divider cleared by write", cnt_value, 32);
    cyc(1'b1);
    chk("R8", "increment after full ratio", cnt_value, 33);
    repeat (7) cyc(1'b1);
    wr_cnt(8'h40, 1'b1);
    chk("R8", "write overrides increment", cnt_value, 64);

    // R9 wrap
    cur_req = "R9";
    wr_mode(6'b001000);
    wr_cnt(8'hFE, 1'b0);
    cyc(1'b1);
    chk("R9", "cnt FF", cnt_value, 255);
    chk("R9", "no ovf at FF", cnt_ovf, 0);
    cyc(1'b1);
    chk("R9", "wrap to 00", cnt_value, 0);
    chk("R9", "ovf pulse", cnt_ovf, 1);
    cyc(1'b0);
    chk("R9", "ovf single cycle", cnt_ovf, 0);

    // R10 mode write clears divider
    cur_req = "R10";
    wr_mode(6'b000001);
    wr_cnt(8'h00, 1'b0);
    repeat (3) cyc(1'b1);
    wr_mode(6'b000001);
    repeat (3) cyc(1'b1);
    chk("R10", "divider cleared by same-value mode write", cnt_value, 0);
    cyc(1'b1);
    chk("R10", "increment after fresh ratio", cnt_value, 1);

    // R2 mixed modes against the model
    cur_req = "R2";
    for (int i = 0; i < 3000; i++) begin
      cyc_en     = 1'($urandom % 2);
      ext_pin    = 1'($urandom % 2);
      mode_we    = (($urandom % 64) == 0);
      mode_wdata = 6'($urandom);
      cnt_we     = (($urandom % 32) == 0);
      cnt_wdata  = 8'($urandom);
      @(negedge clk);
    end
    mode_we = 1'b0; cnt_we = 1'b0; cyc_en = 1'b0;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end
endmodule